// File: doc/BRIEF.md
# Pipelined Two-Phase Bus Memory Target

This block is a word-addressed memory that answers a simple pipelined host bus. Each transfer runs in two phases. In the command phase the host offers an address, a read flag and an opcode. In the data phase that follows, the host supplies write data, or the target returns read data. Both kinds of transfer return a one-bit response. The command phase of the next transfer runs in the same cycle as the data phase of the current one, so at most two transfers are in flight at once.

A single ready output from the target qualifies both phases. A phase finishes only on a rising clock edge where ready is high. When ready is low, the command phase and the data phase both hold. Ready can be pulled low by a pseudo-random wait-state generator. An input turns this generator off, and then ready stays high every cycle and the target takes one transfer per cycle. Accesses that are misaligned, out of range, or use a non-single opcode get an error response and leave memory unchanged.

Top module: `pipebus_mem_target`

## Requirements
- R1: A command is taken when `cmd_valid` is high on a clock edge with `rdy` high, and its data phase occupies the following cycle(s). With wait states off, k back-to-back transfers complete in k+1 cycles.
- R2: A write samples `wr_data` on the edge that completes its data phase and stores it in word `cmd_addr[AW-1:2]`. A write returns `resp` = 0 when no error applies.
- R3: While `rdy` is low, the data-phase transfer and the offered command both hold. Results are taken only on edges where `rdy` is high.
- R4: A read returns `resp` = 0 and the stored word on `rd_data` during its data phase. A read issued right after a write to the same word returns the newly written value.
- R5: `resp` = 1 (ERROR) when `addr[1:0]` is not 2'b00, when the word index is DEPTH or above, or when `cmd_op` is not 2'b00 (single transfer). A write with ERROR does not change memory, and a read with ERROR returns `rd_data` = 0.
- R6: When no data phase is in progress, `resp` and `rd_data` are 0.
- R7: While `rst_n` is low, and in the first cycle after it rises, `rdy` is low. Reset clears every memory word to 0.
- R8: With `stall_en` = 0, `rdy` is high in every cycle after the start-up cycle. With `stall_en` = 1, an LFSR pulls `rdy` low in some cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall_en | input | 1 | Enables pseudo-random wait states |
| cmd_valid | input | 1 | Host offers a command this cycle |
| cmd_addr | input | AW | Byte address of the command |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| cmd_op | input | 2 | Opcode; 2'b00 = single transfer |
| wr_data | input | DW | Write data for the transfer in its data phase |
| rdy | output | 1 | Current phases complete at the next edge |
| resp | output | 1 | 0 = OKAY, 1 = ERROR for the data-phase transfer |
| rd_data | output | DW | Read data for the data-phase transfer |

## Verification
The bench first reads every word, plus two words beyond the memory, to show the reset contents and the range errors. It then writes every byte address across that span. Aligned in-range addresses must update memory, while misaligned or out-of-range ones must return ERROR and change nothing. Two further patterns probe ordering: non-single opcodes aimed at valid words, which must leave those words unchanged, and alternating write/read pairs to the same word, which exercise the read-after-write overlap. A mixed stream then runs again with wait states on. Identical results under wait states show that a stall holds both phases. The bench also compares the cycle counts with and without wait states to show full overlap.

// File: rtl/pipebus_mem_target.sv
`timescale 1ns/1ps
module pipebus_mem_target #(
  parameter int DW = 32,
  parameter int AW = 12,
  parameter int DEPTH = 16,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall_en,
  input  logic          cmd_valid,
  input  logic [AW-1:0] cmd_addr,
  input  logic          cmd_rd,
  input  logic [1:0]    cmd_op,
  input  logic [DW-1:0] wr_data,
  output logic          rdy,
  output logic          resp,
  output logic [DW-1:0] rd_data
);
  localparam int IW = $clog2(DEPTH);
  localparam logic [AW-3:0] WORD_LIM = (AW-2)'(DEPTH);

  logic              started;
  logic [LFSR_W-1:0] lfsr;
  logic              dp_valid;
  logic              dp_rd;
  logic [AW-1:0]     dp_addr;
  logic [1:0]        dp_op;
  logic [DW-1:0]     mem [DEPTH];

  logic [AW-3:0] dp_word;
  logic [IW-1:0] dp_idx;
  logic          dp_err;

  assign dp_word = dp_addr[AW-1:2];
  assign dp_idx  = dp_word[IW-1:0];
  assign dp_err  = (dp_addr[1:0] != 2'b00) || (dp_word >= WORD_LIM) || (dp_op != 2'b00);

  assign rdy     = started & ~(stall_en & (lfsr[1:0] == 2'b00));
  assign resp    = dp_valid & dp_err;
  assign rd_data = (dp_valid & dp_rd & ~dp_err) ? mem[dp_idx] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started  <= 1'b0;
      lfsr     <= LFSR_SEED;
      dp_valid <= 1'b0;
      dp_rd    <= 1'b0;
      dp_addr  <= '0;
      dp_op    <= '0;
    end else begin
      started <= 1'b1;
      lfsr    <= {1'b0, lfsr[LFSR_W-1:1]} ^ (lfsr[0] ? LFSR_TAPS : '0);
      if (rdy) begin
        dp_valid <= cmd_valid;
        dp_rd    <= cmd_rd;
        dp_addr  <= cmd_addr;
        dp_op    <= cmd_op;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (rdy && dp_valid && !dp_rd && !dp_err) begin
      mem[dp_idx] <= wr_data;
    end
  end
endmodule

module pipebus_mem_target_chk #(
  parameter int DW = 32,
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall_en,
  input logic          cmd_valid,
  input logic          rdy,
  input logic          resp,
  input logic [DW-1:0] rd_data,
  input logic          dp_valid,
  input logic          dp_rd,
  input logic [AW-1:0] dp_addr,
  input logic [1:0]    dp_op
);
  a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    rdy && cmd_valid |=> dp_valid);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dp_valid && !rdy |=> dp_valid && $stable(dp_addr) && $stable(dp_rd) && $stable(dp_op));
  a_r5_err_resp: assert property (@(posedge clk) disable iff (!rst_n)
    dp_valid && (dp_addr[1:0] != 2'b00 || dp_op != 2'b00) |-> resp);
  a_r5_err_data: assert property (@(posedge clk) disable iff (!rst_n)
    resp |-> rd_data == '0);
  a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !dp_valid |-> !resp && rd_data == '0);
  a_r7_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rdy);
  a_r8_nostall: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_en && $past(rst_n) |-> rdy);
endmodule

bind pipebus_mem_target pipebus_mem_target_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall_en(stall_en), .cmd_valid(cmd_valid),
  .rdy(rdy), .resp(resp), .rd_data(rd_data), .dp_valid(dp_valid),
  .dp_rd(dp_rd), .dp_addr(dp_addr), .dp_op(dp_op)
);

// File: tb/pipebus_mem_target_bench.sv
`timescale 1ns/1ps
module pipebus_mem_target_bench;
  localparam int DW = 32;
  localparam int AW = 12;
  localparam int DEPTH = 16;
  localparam int NT = 512;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stall_en = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic          cmd_rd = 1'b0;
  logic [1:0]    cmd_op = '0;
  logic [DW-1:0] wr_data = '0;
  logic          rdy;
  logic          resp;
  logic [DW-1:0] rd_data;

  pipebus_mem_target #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_pipebus_mem_target (
    .clk(clk), .rst_n(rst_n), .stall_en(stall_en), .cmd_valid(cmd_valid),
    .cmd_addr(cmd_addr), .cmd_rd(cmd_rd), .cmd_op(cmd_op), .wr_data(wr_data),
    .rdy(rdy), .resp(resp), .rd_data(rd_data)
  );

  always #5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit ended = 1'b0;

  logic [AW-1:0] t_addr [NT];
  logic          t_rd   [NT];
  logic [1:0]    t_op   [NT];
  logic [DW-1:0] t_wd   [NT];
  logic [DW-1:0] model  [DEPTH];
  int n = 0;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic add(input int a, input bit rd, input int op, input logic [DW-1:0] wd);
    t_addr[n] = AW'(a);
    t_rd[n]   = rd;
    t_op[n]   = 2'(op);
    t_wd[n]   = wd;
    n++;
  endtask

  task automatic check_txn(input int i);
    bit err;
    int idx;
    logic [DW-1:0] exp;
    idx = int'(t_addr[i][AW-1:2]);
    err = (t_addr[i][1:0] != 2'b00) || (idx >= DEPTH) || (t_op[i] != 2'b00);
    chk(resp == err, err ? "R5 resp" : (t_rd[i] ? "R4 resp" : "R2 resp"), DW'(resp), DW'(err));
    if (t_rd[i]) begin
      exp = err ? '0 : model[idx];
      chk(rd_data == exp, err ? "R5 rd_data" : "R4 rd_data", rd_data, exp);
    end else if (!err) begin
      model[idx] = t_wd[i];
    end
  endtask

  task automatic run_batch(input int first, input int last, output int cycles, output int stalls);
    int ci = first;
    int di = -1;
    int left = last - first;
    cycles = 0;
    stalls = 0;
    while (left > 0) begin
      @(negedge clk);
      cmd_valid = (ci < last);
      cmd_addr  = (ci < last) ? t_addr[ci] : '0;
      cmd_rd    = (ci < last) ? t_rd[ci] : 1'b0;
      cmd_op    = (ci < last) ? t_op[ci] : 2'b00;
      wr_data   = (di >= 0) ? t_wd[di] : '0;
      #3;
      cycles++;
      if (!rdy) stalls++;
      else begin
        if (di >= 0) begin
          check_txn(di);
          left--;
        end
        if (ci < last) begin
          di = ci;
          ci++;
        end else di = -1;
      end
    end
    @(negedge clk);
    #3;
    chk(resp == 1'b0 && rd_data == '0, "R6 idle outputs", rd_data, '0);
  endtask

  initial begin
    int s, cyc, stl;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    #2;
    chk(rdy == 1'b0 && resp == 1'b0 && rd_data == '0, "R7 reset outputs", DW'(rdy), '0);
    #30;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(rdy == 1'b0, "R7 rdy low first cycle", DW'(rdy), '0);
    @(negedge clk);
    #1;
    chk(rdy == 1'b1, "R8 rdy high after start", DW'(rdy), 32'd1);

    s = n;
    for (int w = 0; w < DEPTH + 2; w++) add(w * 4, 1'b1, 0, '0);
    run_batch(s, n, cyc, stl);
    chk(stl == 0, "R8 no stalls when disabled", DW'(stl), '0);

    s = n;
    for (int a = 0; a < (DEPTH + 2) * 4; a++) add(a, 1'b0, 0, 32'(a * 65539 + 32'h1357_0000));
    for (int op = 1; op < 4; op++) add(op * 4, 1'b0, op, 32'hDEAD_0000 + 32'(op));
    run_batch(s, n, cyc, stl);
    chk(cyc == (n - s) + 1, "R1 back-to-back cycle count", DW'(cyc), DW'((n - s) + 1));

    s = n;
    for (int w = 0; w < DEPTH + 2; w++) add(w * 4, 1'b1, 0, '0);
    add(8, 1'b1, 2, '0);
    run_batch(s, n, cyc, stl);

    s = n;
    for (int w = 0; w < DEPTH; w++) begin
      add(w * 4, 1'b0, 0, 32'hC0DE_0000 ^ 32'(w * 4097));
      add(w * 4, 1'b1, 0, '0);
    end
    run_batch(s, n, cyc, stl);
    chk(cyc == (n - s) + 1, "R1 overlap with read-after-write", DW'(cyc), DW'((n - s) + 1));

    stall_en = 1'b1;
    s = n;
    for (int i = 0; i < 64; i++)
      add((i * 13) % ((DEPTH + 2) * 4), (i % 3) == 0, (i % 7) == 6 ? 1 : 0, 32'h5A5A_0000 + 32'(i * 77));
    run_batch(s, n, cyc, stl);
    chk(stl > 0, "R8 wait states inserted", DW'(stl), 32'd1);
    chk(cyc == (n - s) + 1 + stl, "R3 stalls add cycles only", DW'(cyc), DW'((n - s) + 1 + stl));

    s = n;
    for (int w = 0; w < DEPTH + 2; w++) add(w * 4, 1'b1, 0, '0);
    run_batch(s, n, cyc, stl);

    if (!ended) begin
      ended = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!ended) begin
      ended = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule